// File: doc/BRIEF.md
# Infrared Receive Byte Buffer with Interrupt Flags

This block sits between an infrared pulse encoder and a processor register bus. The encoder hands over one run-length byte per beat on a valid/ready stream, and it pulses a separate strobe when a packet of pulses has ended. The bytes go into a first-in first-out store of parameterised depth. Software drains the store by reading a data word. Each read of that word removes one byte.

Three sticky event flags are collected in a status word: overflow, packet end and data available. The data-available flag follows a fill-level trigger that software programs. The status word also carries the live fill count. An enable word selects which flags drive the single interrupt line. Each flag is cleared by writing a one to its bit.

The stream never applies back-pressure: `in_ready` is held high, so every beat with `in_valid` high is consumed in that cycle. A beat that meets a full store is discarded, and the loss is recorded in the overflow flag instead of stalling the encoder. Register accesses take effect at the clock edge. `reg_rdata` shows the addressed word combinationally during the access.

Top module: `ir_rx_fifo_irq`

## Requirements
- R1: After reset the enable word and the status word read as zero, the interrupt line is low and the store is empty.
- R2: Bytes leave through the data word (address 0, byte in bits 7:0, upper bits zero) in arrival order, and each read of that address removes exactly one byte.
- R3: `in_ready` is always high. A beat that arrives while the store holds DEPTH bytes is dropped, the count stays at DEPTH, and overflow (status bit 0) is set.
- R4: The status word (address 2) carries the current fill count in bits starting at bit 8. The field is $clog2(DEPTH)+1 bits wide.
- R5: A pulse on `in_pkt_end` sets packet end (status bit 1).
- R6: Data available (status bit 4) becomes set one cycle after the fill count exceeds the trigger level. The trigger level is held in enable-word bits starting at bit 8, $clog2(DEPTH) bits wide.
- R7: Writing the status word clears each flag whose bit is written as one and leaves the others untouched. Writing 0xFF clears every flag. A set condition in the same cycle wins over a clear.
- R8: `irq` is high exactly when some flag is set and its enable bit is set. The enable bits sit at the same positions as the flags (bits 0, 1, 4).
- R9: Reading the data word while the store is empty returns zero and leaves the count unchanged.
- R10: The enable word (address 1) reads back its enable bits and trigger level, and every other bit reads as zero.
- R11: A beat and a data read in the same cycle both take effect. The read returns the old head byte. When the store is full, the beat is still dropped and overflow is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Encoder byte valid |
| in_ready | output | 1 | Always high; every beat is consumed |
| in_data | input | DATA_W | Run-length byte from the encoder |
| in_pkt_end | input | 1 | One-cycle packet-end strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word select: 0 data, 1 enable, 2 status |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every trigger level from 0 to DEPTH-1. For each level it fills the store one byte at a time and reads the status word after every beat. This separates an off-by-one in the greater-than trigger from an error in the packed count field. Each fill is drained with a level-dependent byte pattern, which catches reordering or a double pop. Overfilling past DEPTH, with and without a read in the same cycle, shows the difference between dropping a beat and overwriting the head. All eight enable masks are tried against different sets of live flags to pin down the interrupt gating.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_IEN  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

  // event index order inside flag vectors
  localparam int N_EVT   = 3;
  localparam int EVT_OVF = 0;
  localparam int EVT_PKT = 1;
  localparam int EVT_AVL = 2;

  // lowest bit of the level / count fields in the register words
  localparam int FLD_LSB = 8;

  // bit position of an event in the enable and status words
  function automatic int evt_bit(input int e);
    case (e)
      EVT_OVF: return 0;
      EVT_PKT: return 1;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count,
  output logic              drop
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              full, empty, do_push, do_pop;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign drop    = push && full;
  assign head_data = empty ? '0 : store[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == FULL_CNT)); // R3
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == '0) && $stable(rd_ptr)); // R9
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT); // R4
endmodule

// File: rtl/rx_event_flags.sv
module rx_event_flags
  import ir_rx_pkg::*;
#(
  parameter int LVL_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovf_evt,
  input  logic             pkt_evt,
  input  logic [CNT_W-1:0] count,
  input  logic [LVL_W-1:0] level,
  input  logic [N_EVT-1:0] clr,
  input  logic [N_EVT-1:0] ien,
  output logic [N_EVT-1:0] flags,
  output logic             irq
);
  logic [N_EVT-1:0] set;
  logic             above;

  assign above        = (count > CNT_W'(level));
  assign set[EVT_OVF] = ovf_evt;
  assign set[EVT_PKT] = pkt_evt;
  assign set[EVT_AVL] = above;

  for (genvar e = 0; e < N_EVT; e++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[e] <= 1'b0;
      else if (set[e]) flags[e] <= 1'b1;
      else if (clr[e]) flags[e] <= 1'b0;
    end
  end

  assign irq = |(flags & ien);

  AST_OVF_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags[EVT_OVF]); // R3
  AST_PKT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_evt |=> flags[EVT_PKT]); // R5
  AST_AVL_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (count > CNT_W'(level)) |=> flags[EVT_AVL]); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq); // R8
endmodule

// File: rtl/rx_reg_port.sv
module rx_reg_port
  import ir_rx_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [DATA_W-1:0] head_data,
  input  logic [CNT_W-1:0]  count,
  input  logic [N_EVT-1:0]  flags,
  output logic              pop,
  output logic [N_EVT-1:0]  clr,
  output logic [N_EVT-1:0]  ien,
  output logic [LVL_W-1:0]  level
);
  logic wr_ien, wr_stat;
  logic unused_wbits;

  assign wr_ien  = reg_wr && (reg_addr == A_IEN);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign pop     = reg_rd && (reg_addr == A_DATA);
  assign unused_wbits = ^reg_wdata;

  for (genvar e = 0; e < N_EVT; e++) begin : g_evt
    assign clr[e] = wr_stat && reg_wdata[evt_bit(e)];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien[e] <= 1'b0;
      else if (wr_ien) ien[e] <= reg_wdata[evt_bit(e)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level <= '0;
    else if (wr_ien) level <= reg_wdata[FLD_LSB +: LVL_W];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_DATA: reg_rdata[DATA_W-1:0] = head_data;
      A_IEN: begin
        for (int e = 0; e < N_EVT; e++) reg_rdata[evt_bit(e)] = ien[e];
        reg_rdata[FLD_LSB +: LVL_W] = level;
      end
      A_STAT: begin
        for (int e = 0; e < N_EVT; e++) reg_rdata[evt_bit(e)] = flags[e];
        reg_rdata[FLD_LSB +: CNT_W] = count;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ir_rx_fifo_irq.sv
module ir_rx_fifo_irq
  import ir_rx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_pkt_end,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam int LVL_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic [DATA_W-1:0] head_data;
  logic [CNT_W-1:0]  count;
  logic              drop, pop;
  logic [N_EVT-1:0]  flags, clr, ien;
  logic [LVL_W-1:0]  level;

  assign in_ready = 1'b1;

  rx_byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(in_valid), .push_data(in_data), .pop(pop),
    .head_data(head_data), .count(count), .drop(drop)
  );

  rx_event_flags #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .ovf_evt(drop), .pkt_evt(in_pkt_end),
    .count(count), .level(level), .clr(clr), .ien(ien),
    .flags(flags), .irq(irq)
  );

  rx_reg_port #(.REG_W(REG_W), .DATA_W(DATA_W), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .head_data(head_data), .count(count), .flags(flags),
    .pop(pop), .clr(clr), .ien(ien), .level(level)
  );

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready); // R3
endmodule

// File: tb/test_ir_rx_fifo_irq.sv
`timescale 1ns/1ps
module test_ir_rx_fifo_irq;
  localparam int DEPTH = 16;
  localparam int CMASK = 2 * DEPTH - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_pkt_end = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic in_ready, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ir_rx_fifo_irq #(.DEPTH(DEPTH)) i_ir_rx_fifo_irq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_pkt_end(in_pkt_end), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); in_valid = 1'b1; in_data = d;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 v = int'(reg_rdata);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int l, input int n);
    return 8'((l * 37 + n * 11 + 5) & 255);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(1, v); check("R1 enable", v, 0);
    rd(2, v); check("R1 status", v, 0);
    check("R1 irq", int'(irq), 0);
    // R10 enable readback
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); check("R10 readback", v, ((DEPTH - 1) << 8) | 32'h13);
    wr(1, 32'h0);
    // R9 empty read
    rd(0, v); check("R9 empty data", v, 0);
    rd(2, v); check("R9 count", (v >> 8) & CMASK, 0);

    // R6 R4 R2 R7 sweep over every trigger level
    for (int l = 0; l < DEPTH; l++) begin
      wr(1, 32'(l << 8));
      for (int n = 1; n <= DEPTH; n++) begin
        push(pat(l, n));
        @(negedge clk);
        rd(2, v);
        check("R4 R6 status", v, (n << 8) | ((n > l) ? 32'h10 : 0));
      end
      for (int n = 1; n <= DEPTH; n++) begin
        rd(0, v); check("R2 order", v, int'(pat(l, n)));
      end
      wr(2, 32'hFF);
      rd(2, v); check("R7 clear all", v, 0);
      check("R8 irq masked", int'(irq), 0);
    end

    // R3 overflow drops extra beats
    wr(1, 32'h0);
    for (int n = 1; n <= DEPTH + 2; n++) push(pat(99, n));
    @(negedge clk);
    rd(2, v); check("R3 overflow", v, (DEPTH << 8) | 32'h11);
    check("R3 ready", int'(in_ready), 1);
    for (int n = 1; n <= DEPTH; n++) begin
      rd(0, v); check("R3 kept", v, int'(pat(99, n)));
    end
    rd(0, v); check("R9 after drain", v, 0);
    wr(2, 32'hFF);

    // R5 packet end, R7 selective clear, R8 gating
    @(negedge clk); in_pkt_end = 1'b1;
    @(negedge clk); in_pkt_end = 1'b0;
    rd(2, v); check("R5 pkt flag", v, 32'h02);
    check("R8 irq off", int'(irq), 0);
    wr(1, 32'h02);
    check("R8 irq on", int'(irq), 1);
    wr(2, 32'h11);
    rd(2, v); check("R7 other bits kept", v, 32'h02);
    wr(2, 32'h02);
    rd(2, v); check("R7 pkt cleared", v, 0);
    check("R8 irq clear", int'(irq), 0);

    // R8 all masks with three flags, then with only data available
    wr(1, 32'h0);
    for (int n = 1; n <= DEPTH + 1; n++) push(8'(n));
    @(negedge clk); in_pkt_end = 1'b1;
    @(negedge clk); in_pkt_end = 1'b0;
    rd(2, v); check("R8 setup", v & 32'h13, 32'h13);
    for (int m = 0; m < 8; m++) begin
      wr(1, 32'((m & 1) | (m & 2) | ((m & 4) << 2)));
      check("R8 all flags", int'(irq), (m != 0) ? 1 : 0);
    end
    wr(2, 32'h03);
    for (int m = 0; m < 8; m++) begin
      wr(1, 32'((m & 1) | (m & 2) | ((m & 4) << 2)));
      check("R8 avl only", int'(irq), ((m & 4) != 0) ? 1 : 0);
    end
    wr(1, 32'h0);
    for (int n = 1; n <= DEPTH; n++) rd(0, v);
    wr(2, 32'hFF);

    // R11 beat and read in the same cycle
    wr(1, 32'((DEPTH - 1) << 8));
    push(8'hA1); push(8'hB2); push(8'hC3);
    @(negedge clk); in_valid = 1'b1; in_data = 8'hD4; reg_rd = 1'b1; reg_addr = 2'd0;
    #1 v = int'(reg_rdata); check("R11 old head", v, 32'hA1);
    @(negedge clk); in_valid = 1'b0; reg_rd = 1'b0;
    rd(2, v); check("R11 count", (v >> 8) & CMASK, 3);
    rd(0, v); check("R11 order b", v, 32'hB2);
    rd(0, v); check("R11 order c", v, 32'hC3);
    rd(0, v); check("R11 order d", v, 32'hD4);
    wr(2, 32'hFF);
    for (int n = 1; n <= DEPTH; n++) push(pat(7, n));
    @(negedge clk); in_valid = 1'b1; in_data = 8'hEE; reg_rd = 1'b1; reg_addr = 2'd0;
    #1 v = int'(reg_rdata); check("R11 full head", v, int'(pat(7, 1)));
    @(negedge clk); in_valid = 1'b0; reg_rd = 1'b0;
    rd(2, v);
    check("R11 full count", (v >> 8) & CMASK, DEPTH - 1);
    check("R11 full ovf", v & 1, 1);
    for (int n = 2; n <= DEPTH; n++) begin
      rd(0, v); check("R11 full kept", v, int'(pat(7, n)));
    end
    rd(0, v); check("R11 dropped", v, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule